// File: doc/BRIEF.md
# Overlapped Register Window File

This block is the integer register file of a processor whose procedures work inside rotating register windows. Every instruction names one of 32 logical 32-bit registers. A small group of globals is common to all procedures. The other logical registers are taken from a larger circular physical bank, at a position set by a current-window pointer. Neighbouring windows share storage: the registers a caller loads as outgoing arguments are the same physical registers the callee reads as incoming arguments. Because of this, arguments are passed with no copying.

The pipeline reads two operands and writes one result each cycle, using logical register numbers. It pulses a call strobe when it enters a procedure and a return strobe when it leaves one. One window is reserved as a boundary. A call or return that would move the pointer onto it is refused and reported on an overflow or underflow flag, so that spill or fill handling can run outside this block.

Top module: `rwin_regfile`

## Requirements
- R1: Logical registers 0–7 are globals: a value written to one of them is read back from the same logical number in every window.
- R2: Logical 8–15 are the outs, 16–23 the locals and 24–31 the ins. After a call, the callee's logical 24+k reads what the caller wrote to 8+k. After the matching return, the caller's 8+k reads what the callee wrote to 24+k.
- R3: Locals are private. A value written to a local in the callee does not change the caller's local with the same number.
- R4: `win_ptr` decrements modulo NWIN at the clock edge that samples a call, and increments modulo NWIN at the edge that samples a return. From window 0, a call moves to window NWIN-1.
- R5: The bank wraps. The ins of window NWIN-1 are physically the outs of window 0.
- R6: A call whose target window is the reserved window (window 1 by default) leaves `win_ptr` unchanged and raises `win_ovf` for exactly the one cycle after that edge. `win_ptr` never holds the reserved window.
- R7: A return whose target window is the reserved window leaves `win_ptr` unchanged and raises `win_unf` for exactly the one cycle after that edge.
- R8: When call and return are asserted together, the pointer does not move and no flag is raised.
- R9: A write issued in the same cycle as a call is mapped through the window that was current before that call.
- R10: Reads are combinational through the current window. A read of a register that is being written in the same cycle returns the old value. The new value is visible after the edge.
- R11: After reset, `win_ptr` is 0 and both flags are low.
- R12: The two read ports are independent and may address different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_addr | input | 5 | Logical register number, read port A |
| rd_a_data | output | DW | Read data, port A |
| rd_b_addr | input | 5 | Logical register number, read port B |
| rd_b_data | output | DW | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register number to write |
| wr_data | input | DW | Write data |
| call_i | input | 1 | Procedure entry strobe |
| ret_i | input | 1 | Procedure exit strobe |
| win_ptr | output | clog2(NWIN) | Current window pointer |
| win_ovf | output | 1 | Call refused at the reserved window (one-cycle pulse) |
| win_unf | output | 1 | Return refused at the reserved window (one-cycle pulse) |

## Verification
If the window pointer is corrupted, the fault reaches `win_ptr` at the next edge. It also changes read data in the same cycle, because every windowed read is mapped through the pointer. A wrong overlap or wrap in the address mapping shows up only when data crosses a call or return: an argument written before a call reads back wrong through the callee's ins right after the pointer moves. A wrong reserved-window comparison shows up as a missing or misplaced flag pulse, at the seventh consecutive call from window 0 or at the first return out of window 0.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
    localparam int unsigned LREG_W = 5;
    localparam int unsigned SEC_SZ = 8;
    localparam int unsigned WIN_SZ = 2 * SEC_SZ;

    typedef enum logic [1:0] {
        SEC_GLOBAL = 2'd0,
        SEC_OUTS   = 2'd1,
        SEC_LOCALS = 2'd2,
        SEC_INS    = 2'd3
    } sect_e;

    function automatic sect_e sect_of(input logic [LREG_W-1:0] r);
        return sect_e'(r[4:3]);
    endfunction
endpackage

// File: rtl/rwf_map.sv
module rwf_map
    import rwf_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    localparam int unsigned CW = $clog2(NWIN),
    localparam int unsigned NREG = SEC_SZ + NWIN * WIN_SZ,
    localparam int unsigned PW = $clog2(NREG)
) (
    input  logic [CW-1:0]     cwp,
    input  logic [LREG_W-1:0] lreg,
    output logic [PW-1:0]     phys
);
    logic [CW-1:0] next_win;
    logic [PW-1:0] own_base;
    logic [PW-1:0] nbr_base;
    logic [PW-1:0] off;

    always_comb begin
        next_win = (cwp == CW'(NWIN - 1)) ? '0 : cwp + CW'(1);
        own_base = PW'(SEC_SZ) + (PW'(cwp) << 4);
        nbr_base = PW'(SEC_SZ) + (PW'(next_win) << 4);
        off      = PW'(lreg[2:0]);
        unique case (sect_of(lreg))
            SEC_GLOBAL: phys = off;
            SEC_OUTS:   phys = own_base + off;
            SEC_LOCALS: phys = own_base + PW'(SEC_SZ) + off;
            default:    phys = nbr_base + off;
        endcase
    end
endmodule

// File: rtl/rwf_wptr.sv
module rwf_wptr #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned RESV_WIN = 1,
    localparam int unsigned CW = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          ret_i,
    output logic [CW-1:0] cwp,
    output logic          ovf,
    output logic          unf
);
    localparam logic [NWIN-1:0] INV_MASK = NWIN'(1) << RESV_WIN;

    typedef struct packed {
        logic [CW-1:0] cwp;
        logic          ovf;
        logic          unf;
    } wp_state_t;

    wp_state_t st_d, st_q;
    logic [CW-1:0] dec_win, inc_win;

    always_comb begin
        dec_win = (st_q.cwp == '0) ? CW'(NWIN - 1) : st_q.cwp - CW'(1);
        inc_win = (st_q.cwp == CW'(NWIN - 1)) ? '0 : st_q.cwp + CW'(1);
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        if (call_i && !ret_i) begin
            if (INV_MASK[dec_win]) st_d.ovf = 1'b1;
            else                   st_d.cwp = dec_win;
        end else if (ret_i && !call_i) begin
            if (INV_MASK[inc_win]) st_d.unf = 1'b1;
            else                   st_d.cwp = inc_win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cwp = st_q.cwp;
    assign ovf = st_q.ovf;
    assign unf = st_q.unf;
endmodule

// File: rtl/rwf_bank.sv
module rwf_bank #(
    parameter int unsigned DW = 32,
    parameter int unsigned NREG = 136,
    parameter int unsigned NRD = 2,
    localparam int unsigned PW = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [PW-1:0]           widx,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][PW-1:0]  ridx,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    logic [DW-1:0] bank_d [NREG];
    logic [DW-1:0] bank_q [NREG];

    always_comb begin
        bank_d = bank_q;
        if (we) bank_d[widx] = wdata;
    end

    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = bank_q[ridx[p]];
    end
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
    import rwf_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned NWIN = 8,
    parameter int unsigned RESV_WIN = 1,
    localparam int unsigned CW = $clog2(NWIN),
    localparam int unsigned NREG = SEC_SZ + NWIN * WIN_SZ,
    localparam int unsigned PW = $clog2(NREG),
    localparam int unsigned NRD = 2,
    localparam int unsigned NPORT = NRD + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LREG_W-1:0] rd_a_addr,
    output logic [DW-1:0]     rd_a_data,
    input  logic [LREG_W-1:0] rd_b_addr,
    output logic [DW-1:0]     rd_b_data,
    input  logic              wr_en,
    input  logic [LREG_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              call_i,
    input  logic              ret_i,
    output logic [CW-1:0]     win_ptr,
    output logic              win_ovf,
    output logic              win_unf
);
    logic [CW-1:0]                  cwp;
    logic [NPORT-1:0][LREG_W-1:0]   laddr;
    logic [NPORT-1:0][PW-1:0]       paddr;
    logic [NRD-1:0][PW-1:0]         rd_idx;
    logic [NRD-1:0][DW-1:0]         rd_dat;

    rwf_wptr #(.NWIN(NWIN), .RESV_WIN(RESV_WIN)) u_wptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .call_i (call_i),
        .ret_i  (ret_i),
        .cwp    (cwp),
        .ovf    (win_ovf),
        .unf    (win_unf)
    );

    // port order: read A, read B, write (write uses the pre-strobe window)
    assign laddr = {wr_addr, rd_b_addr, rd_a_addr};

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rwf_map #(.NWIN(NWIN)) u_map (
            .cwp  (cwp),
            .lreg (laddr[p]),
            .phys (paddr[p])
        );
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rsel
        assign rd_idx[p] = paddr[p];
    end

    rwf_bank #(.DW(DW), .NREG(NREG), .NRD(NRD)) u_bank (
        .clk   (clk),
        .we    (wr_en),
        .widx  (paddr[NRD]),
        .wdata (wr_data),
        .ridx  (rd_idx),
        .rdata (rd_dat)
    );

    assign rd_a_data = rd_dat[0];
    assign rd_b_data = rd_dat[1];
    assign win_ptr   = cwp;
endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned RESV_WIN = 1,
    localparam int unsigned CW = $clog2(NWIN)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          call_i,
    input logic          ret_i,
    input logic [CW-1:0] win_ptr,
    input logic          win_ovf,
    input logic          win_unf
);
    // R6
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_ovf |-> $past(call_i && !ret_i));
    // R6
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_ovf |-> $stable(win_ptr));
    // R6
    no_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_ptr != CW'(RESV_WIN));
    // R7
    unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_unf |-> $past(ret_i && !call_i));
    // R7
    unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_unf |-> $stable(win_ptr));
    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i == ret_i) |=> ($stable(win_ptr) && !win_ovf && !win_unf));
    // R4
    call_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i) |=> (win_ovf ||
            win_ptr == (($past(win_ptr) == '0) ? CW'(NWIN - 1) : $past(win_ptr) - CW'(1))));
    // R4
    ret_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i) |=> (win_unf ||
            win_ptr == (($past(win_ptr) == CW'(NWIN - 1)) ? '0 : $past(win_ptr) + CW'(1))));
endmodule

bind rwin_regfile rwin_regfile_chk #(.NWIN(NWIN), .RESV_WIN(RESV_WIN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .win_ptr (win_ptr),
    .win_ovf (win_ovf),
    .win_unf (win_unf)
);

// File: tb/rwin_regfile_test.sv
module rwin_regfile_test;
    localparam int CLK_P = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0;
    logic [2:0]    win_ptr;
    logic          win_ovf, win_unf;

    int total = 0;
    int bad = 0;

    always #(CLK_P / 2) clk = ~clk;

    rwin_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .call_i(call_i), .ret_i(ret_i),
        .win_ptr(win_ptr), .win_ovf(win_ovf), .win_unf(win_unf)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic with_call);
        wr_en = 1'b1; wr_addr = a; wr_data = d; call_i = with_call;
        step();
        wr_en = 1'b0; call_i = 1'b0;
    endtask

    task automatic do_call();
        call_i = 1'b1; step(); call_i = 1'b0;
    endtask

    task automatic do_ret();
        ret_i = 1'b1; step(); ret_i = 1'b0;
    endtask

    task automatic rd_a(input logic [4:0] a, output logic [31:0] d);
        rd_a_addr = a; #1; d = rd_a_data;
    endtask

    task automatic t_reset();
        chk("R11 ptr", 32'(win_ptr), 32'd0);
        chk("R11 ovf", 32'(win_ovf), 32'd0);
        chk("R11 unf", 32'(win_unf), 32'd0);
    endtask

    task automatic t_globals();
        logic [31:0] d;
        wr(5'd3, 32'hA0A0_0003, 1'b0);
        do_call();
        chk("R4 call from 0", 32'(win_ptr), 32'd7);
        rd_a(5'd3, d);
        chk("R1 global seen in callee", d, 32'hA0A0_0003);
        wr(5'd5, 32'hB0B0_0005, 1'b0);
        do_ret();
        chk("R4 return to 0", 32'(win_ptr), 32'd0);
        rd_b_addr = 5'd5; rd_a_addr = 5'd3; #1;
        chk("R1 R12 port b global", rd_b_data, 32'hB0B0_0005);
        chk("R12 port a global", rd_a_data, 32'hA0A0_0003);
    endtask

    task automatic t_overlap();
        logic [31:0] d;
        wr(5'd10, 32'hC0C0_000A, 1'b0);
        do_call();
        rd_a(5'd26, d);
        chk("R2 R5 callee in sees caller out", d, 32'hC0C0_000A);
        wr(5'd29, 32'hD0D0_001D, 1'b0);
        do_ret();
        rd_a(5'd13, d);
        chk("R2 caller out sees callee in", d, 32'hD0D0_001D);
    endtask

    task automatic t_locals();
        logic [31:0] d;
        wr(5'd17, 32'hE0E0_0011, 1'b0);
        do_call();
        wr(5'd17, 32'hF0F0_0011, 1'b0);
        rd_a(5'd17, d);
        chk("R3 callee local", d, 32'hF0F0_0011);
        do_ret();
        rd_a(5'd17, d);
        chk("R3 caller local kept", d, 32'hE0E0_0011);
    endtask

    task automatic t_bounds();
        for (int i = 0; i < 6; i++) do_call();
        chk("R4 after six calls", 32'(win_ptr), 32'd2);
        chk("R6 no early ovf", 32'(win_ovf), 32'd0);
        do_call();
        chk("R6 ovf raised", 32'(win_ovf), 32'd1);
        chk("R6 ptr held", 32'(win_ptr), 32'd2);
        step();
        chk("R6 ovf one cycle", 32'(win_ovf), 32'd0);
        for (int i = 0; i < 6; i++) do_ret();
        chk("R4 back to 0", 32'(win_ptr), 32'd0);
        chk("R7 no early unf", 32'(win_unf), 32'd0);
        do_ret();
        chk("R7 unf raised", 32'(win_unf), 32'd1);
        chk("R7 ptr held", 32'(win_ptr), 32'd0);
        step();
        chk("R7 unf one cycle", 32'(win_unf), 32'd0);
    endtask

    task automatic t_both();
        call_i = 1'b1; ret_i = 1'b1;
        step();
        call_i = 1'b0; ret_i = 1'b0;
        chk("R8 ptr unchanged", 32'(win_ptr), 32'd0);
        chk("R8 no ovf", 32'(win_ovf), 32'd0);
        chk("R8 no unf", 32'(win_unf), 32'd0);
    endtask

    task automatic t_wr_call();
        logic [31:0] d;
        do_call();
        wr(5'd20, 32'h0000_7714, 1'b0);
        do_ret();
        wr(5'd20, 32'h1234_0014, 1'b1);
        chk("R9 moved by call", 32'(win_ptr), 32'd7);
        rd_a(5'd20, d);
        chk("R9 callee local untouched", d, 32'h0000_7714);
        do_ret();
        rd_a(5'd20, d);
        chk("R9 write went to old window", d, 32'h1234_0014);
    endtask

    task automatic t_rdwr();
        logic [31:0] d;
        wr(5'd4, 32'h4444_0001, 1'b0);
        wr_en = 1'b1; wr_addr = 5'd4; wr_data = 32'h4444_0002;
        rd_a(5'd4, d);
        chk("R10 same-cycle read old", d, 32'h4444_0001);
        step();
        wr_en = 1'b0;
        rd_a(5'd4, d);
        chk("R10 new value after edge", d, 32'h4444_0002);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 20000);
        total++; bad++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(); step();
        #1;
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_globals();
        t_overlap();
        t_locals();
        t_bounds();
        t_both();
        t_wr_call();
        t_rdwr();
        finish_run();
    end
endmodule